// File: doc/BRIEF.md
# Dual-Lane Double-Precision Greater-or-Equal Comparator

This block compares two packed vectors, each carrying two IEEE-754 binary64 values, lane by lane. For every lane it tests whether the A operand is greater than or equal to the B operand and returns a 64-bit mask for that lane: all ones when the test holds, all zeros when it does not. Alongside the masks it reports two invalid-operation indications, one for signaling NaNs and one for unordered compares. It also reports whether a trap-enabled invalid condition occurred, and in that case holds back the write of the mask vector to its destination.

When the record input is set, the block also gives a 4-bit summary of the lane outcomes: one bit says every lane compared true and one bit says every lane compared false. The surrounding pipeline handles decode, register-file access, status-register merging and exception delivery. It uses the write enable, the flag outputs and the summary exactly as this block produces them. Each accepted operation produces registered results one clock later.

Top module: `dual_fp_ge_unit`

## Requirements
- R1: Lane i of each vector occupies bits [64*i+63 : 64*i]. One cycle after a cycle with `in_valid` high, `out_valid` is high and lane i of `result` is all ones if A(i) >= B(i), otherwise all zeros. After a cycle with `in_valid` low, `out_valid` and `wr_en` are low.
- R2: Ordering follows numeric value. +0 and -0 are equal, so GE holds between them. Infinities are the extremes. Denormals are ordered by value. Among negative numbers, a larger magnitude is smaller.
- R3: A lane in which either operand is a NaN, quiet or signaling, yields an all-zero mask.
- R4: A signaling NaN has an all-ones exponent, a nonzero fraction and fraction bit 51 equal to 0. If either operand of any lane is one, `flag_snan` is set. In that case the lane also raises the unordered flag only when `exc_en` is 0.
- R5: In a lane with no signaling NaN, the unordered flag is raised when either operand is a quiet NaN (fraction bit 51 equal to 1). `flag_vc` is the OR of the per-lane unordered flags. Both flags are reported whether or not the write is suppressed.
- R6: `exc_pending` equals `exc_en` AND (any lane's signaling flag OR any lane's unordered flag). `wr_en` is high exactly when the result is valid and `exc_pending` is low.
- R7: When `rec_en` was 1, `summary_valid` is high. If no exception is pending, `summary` is {all_true, 0, all_false, 0}, with bit 3 = every lane true and bit 1 = every lane false. If an exception is pending, the summary value is not defined.
- R8: When `rec_en` was 0, `summary_valid` is low and `summary` is 0.
- R9: While `rst` is high, every output is driven to zero on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands present this cycle |
| src_a | input | 128 | A operand vector, two binary64 lanes |
| src_b | input | 128 | B operand vector, two binary64 lanes |
| exc_en | input | 1 | Invalid-operation trap enable |
| rec_en | input | 1 | Request the summary nibble |
| out_valid | output | 1 | Registered results valid |
| result | output | 128 | Per-lane GE masks |
| wr_en | output | 1 | Destination write permitted |
| flag_snan | output | 1 | Signaling-NaN invalid indication |
| flag_vc | output | 1 | Unordered-compare invalid indication |
| exc_pending | output | 1 | Trap-enabled invalid condition occurred |
| summary_valid | output | 1 | Summary nibble requested and present |
| summary | output | 4 | {all_true, 0, all_false, 0} |

## Verification
Every result of an accepted operation is due exactly one rising edge after it is presented: the masks, both flags, the pending indication, the write enable and the summary all come from a single register stage. The bench drives operands on a falling edge. It samples all outputs on the next falling edge, half a period after that one register has loaded. It then presents the next vector in the same step, so each comparison is checked in the cycle it lands. A deliberate idle cycle checks that the valid and write-enable outputs drop one edge after `in_valid` falls. The summary is compared only when no exception is pending, because its value is undefined in that case.

// File: rtl/fpge_pkg.sv
package fpge_pkg;
  localparam int unsigned DP_W      = 64;
  localparam int unsigned DP_EXP_W  = 11;
  localparam int unsigned DP_FRAC_W = 52;
  localparam int unsigned SUM_W     = 4;

  // decoded view of one binary64 operand
  typedef struct packed {
    logic            is_nan;
    logic            is_snan;
    logic            is_qnan;
    logic            is_zero;
    logic            sign;
    logic [DP_W-2:0] mag;
  } fp_class_t;

  // outcome of one lane
  typedef struct packed {
    logic ge;
    logic snan;
    logic vc;
  } lane_res_t;
endpackage

// File: rtl/fpge_classify.sv
module fpge_classify
  import fpge_pkg::*;
(
  input  logic [DP_W-1:0] val,
  output fp_class_t       cls
);
  logic exp_ones;
  logic frac_nz;
  logic quiet_bit;

  always_comb begin
    exp_ones    = &val[DP_W-2 -: DP_EXP_W];
    frac_nz     = |val[DP_FRAC_W-1:0];
    quiet_bit   = val[DP_FRAC_W-1];
    cls.is_nan  = exp_ones & frac_nz;
    cls.is_snan = exp_ones & frac_nz & ~quiet_bit;
    cls.is_qnan = exp_ones & frac_nz & quiet_bit;
    cls.is_zero = ~|val[DP_W-2:0];
    cls.sign    = val[DP_W-1];
    cls.mag     = val[DP_W-2:0];
  end
endmodule

// File: rtl/fpge_lane.sv
module fpge_lane
  import fpge_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [DP_W-1:0] a,
  input  logic [DP_W-1:0] b,
  input  logic            exc_en,
  output lane_res_t       res
);
  fp_class_t a_cls;
  fp_class_t b_cls;
  logic      mag_ge;
  logic      mag_le;
  logic      any_nan;

  fpge_classify u_cls_a (.val(a), .cls(a_cls));
  fpge_classify u_cls_b (.val(b), .cls(b_cls));

  always_comb begin
    mag_ge  = a_cls.mag >= b_cls.mag;
    mag_le  = a_cls.mag <= b_cls.mag;
    any_nan = a_cls.is_nan | b_cls.is_nan;
    if (any_nan)                       res.ge = 1'b0;
    else if (a_cls.is_zero && b_cls.is_zero) res.ge = 1'b1;
    else if (a_cls.sign != b_cls.sign) res.ge = ~a_cls.sign;
    else if (!a_cls.sign)              res.ge = mag_ge;
    else                               res.ge = mag_le;
    res.snan = a_cls.is_snan | b_cls.is_snan;
    res.vc   = res.snan ? ~exc_en : (a_cls.is_qnan | b_cls.is_qnan);
  end

  AST_SELF_EQUAL_GE: assert property (@(posedge clk) disable iff (rst)
    (a == b && !a_cls.is_nan) |-> res.ge); // R2
  AST_ZERO_PAIR_GE: assert property (@(posedge clk) disable iff (rst)
    (a[DP_W-2:0] == '0 && b[DP_W-2:0] == '0) |-> res.ge); // R2
  AST_SNAN_MASKED_VC: assert property (@(posedge clk) disable iff (rst)
    (res.snan && !exc_en) |-> res.vc); // R4
endmodule

// File: rtl/fpge_reduce.sv
module fpge_reduce
  import fpge_pkg::*;
#(
  parameter int unsigned LANES = 2
) (
  input  logic [LANES-1:0] lane_ge,
  input  logic [LANES-1:0] lane_snan,
  input  logic [LANES-1:0] lane_vc,
  input  logic             exc_en,
  input  logic             rec_en,
  output logic             any_snan,
  output logic             any_vc,
  output logic             exc_pend,
  output logic [SUM_W-1:0] sum_nib
);
  logic all_true;
  logic all_false;

  always_comb begin
    any_snan  = |lane_snan;
    any_vc    = |lane_vc;
    exc_pend  = exc_en & (any_snan | any_vc);
    all_true  = &lane_ge;
    all_false = ~|lane_ge;
    sum_nib   = (rec_en && !exc_pend) ? {all_true, 1'b0, all_false, 1'b0} : '0;
  end
endmodule

// File: rtl/dual_fp_ge_unit.sv
module dual_fp_ge_unit
  import fpge_pkg::*;
#(
  parameter int unsigned LANES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic [LANES*DP_W-1:0] src_a,
  input  logic [LANES*DP_W-1:0] src_b,
  input  logic                  exc_en,
  input  logic                  rec_en,
  output logic                  out_valid,
  output logic [LANES*DP_W-1:0] result,
  output logic                  wr_en,
  output logic                  flag_snan,
  output logic                  flag_vc,
  output logic                  exc_pending,
  output logic                  summary_valid,
  output logic [SUM_W-1:0]      summary
);
  localparam int unsigned VEC_W = LANES * DP_W;

  logic [LANES-1:0] lane_ge;
  logic [LANES-1:0] lane_snan;
  logic [LANES-1:0] lane_vc;
  logic [VEC_W-1:0] mask;
  logic             any_snan;
  logic             any_vc;
  logic             exc_pend;
  logic [SUM_W-1:0] sum_nib;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lane_res_t lr;
    fpge_lane u_lane (
      .clk   (clk),
      .rst   (rst),
      .a     (src_a[g*DP_W +: DP_W]),
      .b     (src_b[g*DP_W +: DP_W]),
      .exc_en(exc_en),
      .res   (lr)
    );
    assign lane_ge[g]   = lr.ge;
    assign lane_snan[g] = lr.snan;
    assign lane_vc[g]   = lr.vc;
    assign mask[g*DP_W +: DP_W] = {DP_W{lr.ge}};
  end

  fpge_reduce #(.LANES(LANES)) u_reduce (
    .lane_ge  (lane_ge),
    .lane_snan(lane_snan),
    .lane_vc  (lane_vc),
    .exc_en   (exc_en),
    .rec_en   (rec_en),
    .any_snan (any_snan),
    .any_vc   (any_vc),
    .exc_pend (exc_pend),
    .sum_nib  (sum_nib)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid     <= 1'b0;
      result        <= '0;
      wr_en         <= 1'b0;
      flag_snan     <= 1'b0;
      flag_vc       <= 1'b0;
      exc_pending   <= 1'b0;
      summary_valid <= 1'b0;
      summary       <= '0;
    end else begin
      out_valid     <= in_valid;
      result        <= in_valid ? mask : '0;
      wr_en         <= in_valid & ~exc_pend;
      flag_snan     <= in_valid & any_snan;
      flag_vc       <= in_valid & any_vc;
      exc_pending   <= in_valid & exc_pend;
      summary_valid <= in_valid & rec_en;
      summary       <= in_valid ? sum_nib : '0;
    end
  end

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R1
  AST_WR_NEEDS_CLEAN: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (out_valid && !exc_pending)); // R6
  AST_EXC_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    exc_pending |-> (flag_snan || flag_vc)); // R6
  AST_SUM_NOT_BOTH: assert property (@(posedge clk) disable iff (rst)
    (summary_valid && !exc_pending) |-> !(summary[3] && summary[1])); // R7
  AST_SUM_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (summary_valid && !exc_pending) |-> (summary[2] == 1'b0 && summary[0] == 1'b0)); // R7
  AST_NOREC_ZERO: assert property (@(posedge clk) disable iff (rst)
    !summary_valid |-> (summary == '0)); // R8
endmodule

// File: tb/test_dual_fp_ge_unit.sv
module test_dual_fp_ge_unit;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [127:0] src_a = '0;
  logic [127:0] src_b = '0;
  logic         exc_en = 1'b0;
  logic         rec_en = 1'b0;
  logic         out_valid;
  logic [127:0] result;
  logic         wr_en;
  logic         flag_snan;
  logic         flag_vc;
  logic         exc_pending;
  logic         summary_valid;
  logic [3:0]   summary;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  dual_fp_ge_unit i_dual_fp_ge_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src_a(src_a), .src_b(src_b),
    .exc_en(exc_en), .rec_en(rec_en), .out_valid(out_valid), .result(result),
    .wr_en(wr_en), .flag_snan(flag_snan), .flag_vc(flag_vc),
    .exc_pending(exc_pending), .summary_valid(summary_valid), .summary(summary)
  );

  localparam logic [63:0] P_ZERO = 64'h0000_0000_0000_0000;
  localparam logic [63:0] N_ZERO = 64'h8000_0000_0000_0000;
  localparam logic [63:0] P_ONE  = 64'h3FF0_0000_0000_0000;
  localparam logic [63:0] N_ONE  = 64'hBFF0_0000_0000_0000;
  localparam logic [63:0] N_TWO  = 64'hC000_0000_0000_0000;
  localparam logic [63:0] P_INF  = 64'h7FF0_0000_0000_0000;
  localparam logic [63:0] N_INF  = 64'hFFF0_0000_0000_0000;
  localparam logic [63:0] P_MAX  = 64'h7FEF_FFFF_FFFF_FFFF;
  localparam logic [63:0] P_DEN  = 64'h0000_0000_0000_0001;
  localparam logic [63:0] N_DEN  = 64'h8000_0000_0000_0003;
  localparam logic [63:0] Q_NAN  = 64'h7FF8_0000_0000_0000;
  localparam logic [63:0] S_NAN  = 64'h7FF0_0000_0000_0001;

  function automatic logic is_nan(input logic [63:0] x);
    return (x[62:52] == 11'h7FF) && (x[51:0] != 52'd0);
  endfunction
  function automatic logic is_snan(input logic [63:0] x);
    return is_nan(x) && !x[51];
  endfunction
  function automatic logic is_qnan(input logic [63:0] x);
    return is_nan(x) && x[51];
  endfunction
  function automatic logic ref_ge(input logic [63:0] a, input logic [63:0] b);
    if (is_nan(a) || is_nan(b)) return 1'b0;
    return $bitstoreal(a) >= $bitstoreal(b);
  endfunction

  function automatic logic [63:0] gen_op(input logic [63:0] other);
    int unsigned k = $urandom_range(0, 11);
    logic        s = 1'($urandom_range(0, 1));
    logic [63:0] r = {$urandom(), $urandom()};
    case (k)
      3:       return {s, 11'h7FF, 1'b1, r[50:0]};
      4:       return {s, 11'h7FF, 1'b0, r[50:1], 1'b1};
      5:       return {s, 11'h7FF, 52'd0};
      6:       return {s, 63'd0};
      7:       return {s, 11'h000, r[51:0]};
      8:       return other;
      9:       return {~other[63], other[62:0]};
      10:      return other + 64'd1;
      11:      return other - 64'd1;
      default: return r;
    endcase
  endfunction

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // caller sits at a falling edge; drive, wait one register stage, check
  task automatic apply(input logic [63:0] a1, input logic [63:0] a0,
                       input logic [63:0] b1, input logic [63:0] b0,
                       input logic en, input logic rec, input string why);
    logic [1:0]   ge;
    logic [1:0]   sn;
    logic [1:0]   vc;
    logic [127:0] exp_res;
    logic         exp_exc;
    logic [63:0]  av [2];
    logic [63:0]  bv [2];
    av[0] = a0; av[1] = a1; bv[0] = b0; bv[1] = b1;
    for (int i = 0; i < 2; i++) begin
      ge[i] = ref_ge(av[i], bv[i]);
      sn[i] = is_snan(av[i]) || is_snan(bv[i]);
      vc[i] = sn[i] ? !en : (is_qnan(av[i]) || is_qnan(bv[i]));
    end
    exp_res = {{64{ge[1]}}, {64{ge[0]}}};
    exp_exc = en && ((|sn) || (|vc));
    src_a = {a1, a0}; src_b = {b1, b0};
    exc_en = en; rec_en = rec; in_valid = 1'b1;
    @(negedge clk);
    check({"R1 out_valid ", why}, 128'(out_valid), 128'(1'b1));
    check({"R1 R2 R3 result ", why}, result, exp_res);
    check({"R4 flag_snan ", why}, 128'(flag_snan), 128'(|sn));
    check({"R5 flag_vc ", why}, 128'(flag_vc), 128'(|vc));
    check({"R6 exc_pending ", why}, 128'(exc_pending), 128'(exp_exc));
    check({"R6 wr_en ", why}, 128'(wr_en), 128'(!exp_exc));
    check({"R7 R8 summary_valid ", why}, 128'(summary_valid), 128'(rec));
    if (!rec)
      check({"R8 summary ", why}, 128'(summary), 128'(0));
    else if (!exp_exc)
      check({"R7 summary ", why}, 128'(summary), 128'({&ge, 1'b0, ~|ge, 1'b0}));
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h00C0_FFEE));
    src_a = {64{2'b10}};
    in_valid = 1'b1;
    repeat (3) @(negedge clk);
    // R9: reset clears everything
    check("R9 out_valid", 128'(out_valid), 128'(0));
    check("R9 result", result, 128'(0));
    check("R9 wr_en", 128'(wr_en), 128'(0));
    check("R9 flags", 128'({flag_snan, flag_vc, exc_pending}), 128'(0));
    check("R9 summary", 128'({summary_valid, summary}), 128'(0));
    in_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);

    // directed corners
    apply(P_ZERO, N_ZERO, N_ZERO, P_ZERO, 1'b0, 1'b1, "R2 signed zeros");
    apply(N_ONE, N_TWO, N_TWO, N_ONE, 1'b0, 1'b1, "R2 negatives");
    apply(P_INF, N_INF, P_MAX, N_INF, 1'b0, 1'b1, "R2 infinities");
    apply(P_DEN, N_DEN, P_ZERO, N_ZERO, 1'b0, 1'b1, "R2 denormals");
    apply(N_DEN, P_ONE, P_ZERO, P_INF, 1'b0, 1'b1, "R7 all false");
    apply(Q_NAN, P_ONE, Q_NAN, P_ONE, 1'b0, 1'b1, "R3 R5 qnan no trap");
    apply(Q_NAN, P_ONE, P_ONE, P_ONE, 1'b1, 1'b1, "R5 R6 qnan trap");
    apply(P_ONE, S_NAN, P_ONE, P_ONE, 1'b0, 1'b1, "R4 snan no trap");
    apply(P_ONE, S_NAN, P_ONE, Q_NAN, 1'b1, 1'b0, "R4 R6 snan trap");
    apply(P_ONE, P_ONE, N_ONE, P_ZERO, 1'b1, 1'b0, "R8 no record");

    // idle cycle: valid and write enable drop
    in_valid = 1'b0;
    @(negedge clk);
    check("R1 idle out_valid", 128'(out_valid), 128'(0));
    check("R1 idle wr_en", 128'(wr_en), 128'(0));

    // random mix
    for (int n = 0; n < 2500; n++) begin
      logic [63:0] b0 = {$urandom(), $urandom()};
      logic [63:0] b1 = {$urandom(), $urandom()};
      logic [63:0] a0 = gen_op(b0);
      logic [63:0] a1 = gen_op(b1);
      apply(a1, a0, b1, b0, ($urandom_range(0, 3) == 0), 1'($urandom_range(0, 1)), "random");
    end

    in_valid = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule